// File: doc/BRIEF.md
# Address Translation Unit with Cached Mappings and Two-Level Table Walk

This block turns 32-bit virtual addresses into physical addresses for one address space. A small fully associative mapping cache compares the page number of each request against all of its entries in the same cycle. On a hit the translation is returned one cycle after the request is accepted, with no memory traffic.

On a miss, or on a write to a cached page not yet marked modified, a sequential walker reads the top-level and second-level table words from a word-addressed memory port. It checks presence and access rights, and sets the referenced and modified flags in the table entry. When either flag changes it writes the entry back. It then loads the mapping into the cache and returns the frame number joined with the 12-bit page offset. An absent mapping or a forbidden access returns a fault code instead of an address.

Top module: `vm_xlat`

## Requirements
- R1: A successful response carries `rsp_paddr` = {frame number from table entry bits 31:12, `req_vaddr[11:0]`}, with the offset bits unchanged.
- R2: A request whose page number is cached, and which needs no flag update, responds in the cycle after acceptance and issues no memory read or write.
- R3: On a miss the walker reads the word at `root_base + vaddr[31:22]`, then the word at {top entry bits (12+MEM_AW-11):12, `vaddr[21:12]`}. It never reads and writes memory in the same cycle, and a walk without write-back responds 5 cycles after acceptance.
- R4: Table entry bit 0 is the present flag. If it is 0 at the top level (one read, response 3 cycles after acceptance) or at the second level, the response has `rsp_fault`=1 and `rsp_paddr`=0, and no mapping is cached, so a repeat walks again.
- R5: Access kind 0 reads and needs entry bit 1, kind 1 writes and needs bit 2, kind 2 fetches and needs bit 3, and kind 3 is treated as a read. A forbidden access returns `rsp_fault`=2 and `rsp_paddr`=0, and writes nothing to memory. This holds on a cache hit as well.
- R6: A permitted walk sets bit 4 (referenced), and sets bit 5 (modified) for a write. If the word changed, it is written back to the same address before the response, 6 cycles after acceptance. If the word did not change, nothing is written.
- R7: A write that hits a cached entry not yet modified walks again and updates that same entry, leaving no duplicate. The next write to the page is a plain hit.
- R8: A fill uses the lowest-numbered empty slot. When the cache is full it uses a round-robin slot pointer that starts at slot 0 and advances by one on each such fill.
- R9: A one-cycle `flush_all` pulse empties every slot and resets the round-robin pointer to 0, so the next access to any page walks.
- R10: `req_ready` is 1 after reset and in idle, and 0 from acceptance until the response. A request held during a walk produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Empty the mapping cache |
| root_base | input | MEM_AW | Word address of the top-level table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 denied |
| mem_rd_en | output | 1 | Table read; data returns the following cycle |
| mem_wr_en | output | 1 | Table entry write-back |
| mem_addr | output | MEM_AW | Table word address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd_en` |

## Verification
Stimulus covers a clean page read, then a repeated read of that page, which separates the walk path from the hit path by latency and read count. Writes to clean pages and to already-flagged pages show whether write-back happens only when a flag changes. Absent entries at each level and forbidden kinds, both walked and cached, separate the two fault codes and the one-read and two-read walk lengths. Filling all 64 slots from empty and then overflowing, with probes for surviving pages, shows the order of victim selection. Flushing and holding a request during a walk complete the set.

// File: rtl/vm_xlat_pkg.sv
package vm_xlat_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int LVL_W = 10;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 20;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int PTE_W = 32;

    // table entry flag positions
    localparam int B_V   = 0;
    localparam int B_R   = 1;
    localparam int B_W   = 2;
    localparam int B_X   = 3;
    localparam int B_REF = 4;
    localparam int B_MOD = 5;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_DENIED = 2'd2
    } fault_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             pr;
        logic             pw;
        logic             px;
        logic             dirty;
    } tlb_ent_t;

    function automatic logic perm_ok(input logic [1:0] kind, input logic pr,
                                     input logic pw, input logic px);
        case (kind)
            2'd1:    return pw;
            2'd2:    return px;
            default: return pr;
        endcase
    endfunction
endpackage

// File: rtl/vm_xlat_cam.sv
module vm_xlat_cam
    import vm_xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [VPN_W-1:0]      lk_vpn,
    output logic                  lk_hit,
    output logic [(ENTRIES>1 ? $clog2(ENTRIES) : 1)-1:0] lk_idx,
    output tlb_ent_t              lk_ent,
    input  logic                  wr_en,
    input  logic                  wr_reuse,
    input  logic [(ENTRIES>1 ? $clog2(ENTRIES) : 1)-1:0] wr_reuse_idx,
    input  tlb_ent_t              wr_ent
);
    localparam int SLOT_W = ENTRIES > 1 ? $clog2(ENTRIES) : 1;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]     valid;
        tlb_ent_t [ENTRIES-1:0] ent;
        logic [SLOT_W-1:0]      rr;
    } cam_st_t;

    cam_st_t q, d;
    logic [ENTRIES-1:0] match;
    logic               have_free;
    logic [SLOT_W-1:0]  free_idx;
    logic [SLOT_W-1:0]  slot;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = q.valid[g] && (q.ent[g].vpn == lk_vpn);
    end

    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) lk_idx = SLOT_W'(i);
        lk_hit = |match;
        lk_ent = q.ent[lk_idx];

        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!q.valid[i]) begin
                have_free = 1'b1;
                free_idx  = SLOT_W'(i);
            end
        end

        d    = q;
        slot = wr_reuse ? wr_reuse_idx : (have_free ? free_idx : q.rr);
        if (wr_en) begin
            d.valid[slot] = 1'b1;
            d.ent[slot]   = wr_ent;
            if (!wr_reuse && !have_free)
                d.rr = (q.rr == LAST) ? '0 : q.rr + 1'b1;
        end
        if (flush) begin
            d.valid = '0;
            d.rr    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (q.valid == '0)); // R9
endmodule

// File: rtl/vm_xlat_walk.sv
module vm_xlat_walk
    import vm_xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int MEM_AW  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MEM_AW-1:0]  root_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_kind,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [PTE_W-1:0]   mem_wdata,
    input  logic [PTE_W-1:0]   mem_rdata,
    output logic [VPN_W-1:0]   lk_vpn,
    input  logic               lk_hit,
    input  logic [(ENTRIES>1 ? $clog2(ENTRIES) : 1)-1:0] lk_idx,
    input  tlb_ent_t           lk_ent,
    output logic               fill_en,
    output logic               fill_reuse,
    output logic [(ENTRIES>1 ? $clog2(ENTRIES) : 1)-1:0] fill_idx,
    output tlb_ent_t           fill_ent
);
    localparam int SLOT_W = ENTRIES > 1 ? $clog2(ENTRIES) : 1;
    localparam int PTR_W  = MEM_AW - LVL_W;
    localparam int L1_LSB = OFF_W + LVL_W;

    typedef enum logic [2:0] {
        W_IDLE, W_L1_RD, W_L1_CHK, W_L2_RD, W_L2_CHK, W_WB
    } wstate_e;

    typedef struct packed {
        wstate_e           st;
        logic [VA_W-1:0]   va;
        logic [1:0]        kind;
        logic              reuse;
        logic [SLOT_W-1:0] ridx;
        logic [MEM_AW-1:0] l2a;
        logic [PTE_W-1:0]  pte;
        logic              rv;
        logic [PA_W-1:0]   rpa;
        fault_e            rf;
    } walk_st_t;

    walk_st_t         q, d;
    logic             done;
    logic [PTE_W-1:0] done_pte;
    logic [PTE_W-1:0] upd;

    assign lk_vpn    = req_vaddr[VA_W-1 -: VPN_W];
    assign rsp_valid = q.rv;
    assign rsp_paddr = q.rpa;
    assign rsp_fault = q.rf;

    always_comb begin
        d         = q;
        d.rv      = 1'b0;
        d.rpa     = '0;
        d.rf      = FLT_NONE;
        req_ready = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        done_pte  = '0;
        upd       = mem_rdata | (PTE_W'(1) << B_REF)
                  | ((q.kind == 2'd1) ? (PTE_W'(1) << B_MOD) : '0);

        case (q.st)
            W_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (lk_hit && !perm_ok(req_kind, lk_ent.pr, lk_ent.pw, lk_ent.px)) begin
                        d.rv = 1'b1;
                        d.rf = FLT_DENIED;
                    end else if (lk_hit && !(req_kind == 2'd1 && !lk_ent.dirty)) begin
                        d.rv  = 1'b1;
                        d.rpa = {lk_ent.pfn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        d.va    = req_vaddr;
                        d.kind  = req_kind;
                        d.reuse = lk_hit;
                        d.ridx  = lk_idx;
                        d.st    = W_L1_RD;
                    end
                end
            end
            W_L1_RD: begin
                mem_rd_en = 1'b1;
                mem_addr  = root_base + MEM_AW'(q.va[L1_LSB +: LVL_W]);
                d.st      = W_L1_CHK;
            end
            W_L1_CHK: begin
                if (!mem_rdata[B_V]) begin
                    d.rv = 1'b1;
                    d.rf = FLT_ABSENT;
                    d.st = W_IDLE;
                end else begin
                    d.l2a = {mem_rdata[OFF_W +: PTR_W], q.va[OFF_W +: LVL_W]};
                    d.st  = W_L2_RD;
                end
            end
            W_L2_RD: begin
                mem_rd_en = 1'b1;
                mem_addr  = q.l2a;
                d.st      = W_L2_CHK;
            end
            W_L2_CHK: begin
                if (!mem_rdata[B_V]) begin
                    d.rv = 1'b1;
                    d.rf = FLT_ABSENT;
                    d.st = W_IDLE;
                end else if (!perm_ok(q.kind, mem_rdata[B_R], mem_rdata[B_W], mem_rdata[B_X])) begin
                    d.rv = 1'b1;
                    d.rf = FLT_DENIED;
                    d.st = W_IDLE;
                end else if (upd != mem_rdata) begin
                    d.pte = upd;
                    d.st  = W_WB;
                end else begin
                    done     = 1'b1;
                    done_pte = mem_rdata;
                end
            end
            W_WB: begin
                mem_wr_en = 1'b1;
                mem_addr  = q.l2a;
                mem_wdata = q.pte;
                done      = 1'b1;
                done_pte  = q.pte;
            end
            default: d.st = W_IDLE;
        endcase

        fill_en        = done;
        fill_reuse     = q.reuse;
        fill_idx       = q.ridx;
        fill_ent.vpn   = q.va[VA_W-1 -: VPN_W];
        fill_ent.pfn   = done_pte[PTE_W-1 -: PFN_W];
        fill_ent.pr    = done_pte[B_R];
        fill_ent.pw    = done_pte[B_W];
        fill_ent.px    = done_pte[B_X];
        fill_ent.dirty = done_pte[B_MOD];
        if (done) begin
            d.rv  = 1'b1;
            d.rpa = {done_pte[PTE_W-1 -: PFN_W], q.va[OFF_W-1:0]};
            d.st  = W_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= W_IDLE;
        end else begin
            q <= d;
        end
    end

    AST_FAULT_NO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0)); // R4
    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2)); // R6
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R3
    AST_NO_READY_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready); // R10
    AST_HIT_VPN: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_ent.vpn == lk_vpn)); // R2
    AST_FILL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (rsp_valid && rsp_fault == FLT_NONE)); // R1
endmodule

// File: rtl/vm_xlat.sv
module vm_xlat
    import vm_xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int MEM_AW  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_all,
    input  logic [MEM_AW-1:0]  root_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_vaddr,
    input  logic [1:0]         req_kind,
    output logic               rsp_valid,
    output logic [31:0]        rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata
);
    localparam int SLOT_W = ENTRIES > 1 ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0]  lk_vpn;
    logic              lk_hit;
    logic [SLOT_W-1:0] lk_idx;
    tlb_ent_t          lk_ent;
    logic              fill_en;
    logic              fill_reuse;
    logic [SLOT_W-1:0] fill_idx;
    tlb_ent_t          fill_ent;

    vm_xlat_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush_all),
        .lk_vpn       (lk_vpn),
        .lk_hit       (lk_hit),
        .lk_idx       (lk_idx),
        .lk_ent       (lk_ent),
        .wr_en        (fill_en),
        .wr_reuse     (fill_reuse),
        .wr_reuse_idx (fill_idx),
        .wr_ent       (fill_ent)
    );

    vm_xlat_walk #(.ENTRIES(ENTRIES), .MEM_AW(MEM_AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .root_base  (root_base),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_kind   (req_kind),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .lk_vpn     (lk_vpn),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .lk_ent     (lk_ent),
        .fill_en    (fill_en),
        .fill_reuse (fill_reuse),
        .fill_idx   (fill_idx),
        .fill_ent   (fill_ent)
    );
endmodule

// File: tb/vm_xlat_bench.sv
module vm_xlat_bench;
    localparam int CLK_P = 10;
    localparam int N     = 64;
    localparam int AW    = 12;
    localparam logic [31:0] FV = 32'h1, FR = 32'h2, FW = 32'h4, FX = 32'h8,
                            FREF = 32'h10, FMOD = 32'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_all = 1'b0;
    logic [AW-1:0] root_base = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_vaddr = '0;
    logic [1:0]    req_kind = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_paddr;
    logic [1:0]    rsp_fault;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    logic [31:0] mem [0:(1<<AW)-1];
    int n_rd = 0, n_wr = 0;
    int n_tests = 0, n_fail = 0;

    vm_xlat #(.ENTRIES(N), .MEM_AW(AW)) u_vm_xlat (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            n_rd <= n_rd + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            n_wr <= n_wr + 1;
        end
    end

    function automatic logic [31:0] pte(input logic [19:0] pfn, input logic [31:0] fl);
        return {pfn, 12'h000} | fl;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic acc(input logic [31:0] va, input logic [1:0] k,
                       output logic [1:0] f, output logic [31:0] pa,
                       output int cyc, output int rd, output int wr, output bit busy_ok);
        int r0, w0;
        @(negedge clk);
        r0 = n_rd; w0 = n_wr;
        req_valid = 1'b1; req_vaddr = va; req_kind = k;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; busy_ok = 1'b1;
        while (!rsp_valid && cyc < 40) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        f = rsp_fault; pa = rsp_paddr;
        rd = n_rd - r0; wr = n_wr - w0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R10 no response after reset", rsp_valid, 0);
        chk(mem_rd_en == 1'b0, "R3 no read after reset", mem_rd_en, 0);
    endtask

    task automatic t_miss_read();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        acc(32'h0000_5abc, 2'd0, f, pa, c, rd, wr, b);
        chk(f == 2'd0, "R1 miss fault", f, 0);
        chk(pa == 32'h1234_5abc, "R1 miss paddr", pa, 32'h1234_5abc);
        chk(rd == 2, "R3 two table reads", rd, 2);
        chk(wr == 1, "R6 referenced write-back", wr, 1);
        chk(c == 6, "R6 latency with write-back", c, 6);
        chk(mem[1029] == pte(20'h12345, FV|FR|FW|FREF), "R6 referenced set", mem[1029],
            pte(20'h12345, FV|FR|FW|FREF));
        chk(b, "R10 ready low during walk", b, 1);
    endtask

    task automatic t_hit();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        acc(32'h0000_5123, 2'd0, f, pa, c, rd, wr, b);
        chk(c == 1, "R2 hit latency", c, 1);
        chk(rd == 0 && wr == 0, "R2 hit no memory access", rd + wr, 0);
        chk(pa == 32'h1234_5123, "R1 hit offset passthrough", pa, 32'h1234_5123);
    endtask

    task automatic t_write_clean();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        acc(32'h0000_5004, 2'd1, f, pa, c, rd, wr, b);
        chk(rd == 2 && wr == 1, "R7 write to clean entry walks", rd * 10 + wr, 21);
        chk(mem[1029][5] == 1'b1, "R6 modified set on write", mem[1029], 1);
        chk(pa == 32'h1234_5004 && f == 2'd0, "R7 write paddr", pa, 32'h1234_5004);
        acc(32'h0000_5008, 2'd1, f, pa, c, rd, wr, b);
        chk(c == 1 && rd == 0, "R7 second write hits", c, 1);
    endtask

    task automatic t_no_change();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        acc(32'h0000_6010, 2'd1, f, pa, c, rd, wr, b);
        chk(wr == 0, "R6 no write when flags already set", wr, 0);
        chk(c == 5, "R3 walk latency without write-back", c, 5);
        chk(pa == 32'h00ab_c010, "R1 paddr flagged page", pa, 32'h00abc010);
    endtask

    task automatic t_absent();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        acc(32'h0000_7000, 2'd0, f, pa, c, rd, wr, b);
        chk(f == 2'd1, "R4 second-level absent fault", f, 1);
        chk(pa == 32'h0, "R4 fault paddr zero", pa, 0);
        chk(c == 5 && rd == 2, "R4 second-level absent walk", c, 5);
        acc(32'h0000_7000, 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 2, "R4 absent not cached", rd, 2);
        acc(32'h0040_0000, 2'd0, f, pa, c, rd, wr, b);
        chk(f == 2'd1, "R4 top-level absent fault", f, 1);
        chk(rd == 1 && c == 3, "R4 top-level absent one read", rd * 10 + c, 13);
    endtask

    task automatic t_denied();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        acc(32'h0000_8000, 2'd1, f, pa, c, rd, wr, b);
        chk(f == 2'd2, "R5 write denied", f, 2);
        chk(wr == 0 && pa == 32'h0, "R5 denied no write, zero paddr", wr, 0);
        chk(mem[1032] == pte(20'h00777, FV|FR|FX|FREF), "R5 entry unchanged", mem[1032],
            pte(20'h00777, FV|FR|FX|FREF));
        acc(32'h0000_8000, 2'd2, f, pa, c, rd, wr, b);
        chk(f == 2'd0 && pa == 32'h0077_7000, "R5 fetch allowed", pa, 32'h00777000);
        acc(32'h0000_8004, 2'd1, f, pa, c, rd, wr, b);
        chk(f == 2'd2 && c == 1 && rd == 0, "R5 denied on hit", f, 2);
        acc(32'h0000_8008, 2'd3, f, pa, c, rd, wr, b);
        chk(f == 2'd0 && c == 1, "R5 kind 3 acts as read", f, 0);
    endtask

    task automatic t_flush();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        acc(32'h0000_5000, 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 0, "R9 cached before flush", rd, 0);
        pulse_flush();
        acc(32'h0000_5000, 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 2, "R9 walk after flush", rd, 2);
    endtask

    task automatic t_replace();
        logic [1:0] f; logic [31:0] pa; int c, rd, wr; bit b;
        int bad = 0;
        pulse_flush();
        for (int j = 0; j < N; j++) begin
            acc((32'd2 << 22) | (j << 12), 2'd0, f, pa, c, rd, wr, b);
            if (rd != 2) bad++;
        end
        chk(bad == 0, "R8 empty slots filled by misses", bad, 0);
        acc((32'd2 << 22) | (N << 12) | 32'h3c, 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 2 && pa == 32'h4004_003c, "R8 overflow fill", pa, 32'h4004003c);
        acc((32'd2 << 22) | (1 << 12), 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 0, "R8 slot 1 survives", rd, 0);
        acc((32'd2 << 22), 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 2, "R8 slot 0 was victim", rd, 2);
        acc((32'd2 << 22) | (1 << 12), 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 2, "R8 pointer advanced to slot 1", rd, 2);
        acc((32'd2 << 22) | (3 << 12), 2'd0, f, pa, c, rd, wr, b);
        chk(rd == 0, "R8 slot 3 survives", rd, 0);
    endtask

    task automatic t_hold();
        int r0, nrsp = 0;
        bit busy = 1'b1;
        @(negedge clk);
        r0 = n_rd;
        req_valid = 1'b1; req_vaddr = 32'h0000_6000; req_kind = 2'd0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (rsp_valid) begin
                nrsp++;
                req_valid = 1'b0;
            end else if (req_valid && req_ready) begin
                busy = 1'b0;
            end
        end
        req_valid = 1'b0;
        chk(nrsp == 1, "R10 one response for held request", nrsp, 1);
        chk(busy, "R10 ready low while walking", busy, 1);
        chk(n_rd - r0 == 2, "R10 one walk for held request", n_rd - r0, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
        mem[0] = pte(20'd1, FV);
        mem[2] = pte(20'd2, FV);
        mem[1029] = pte(20'h12345, FV|FR|FW);
        mem[1030] = pte(20'h00abc, FV|FR|FW|FREF|FMOD);
        mem[1032] = pte(20'h00777, FV|FR|FX|FREF);
        for (int j = 0; j <= N; j++) mem[2048 + j] = pte(20'h40000 + 20'(j), FV|FR|FREF);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_read();
        t_hit();
        t_write_clean();
        t_no_change();
        t_absent();
        t_denied();
        t_flush();
        t_replace();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule